// File: doc/BRIEF.md
# Round-Robin VOQ Matching Scheduler

This block computes the crossbar configuration of an N-by-N input-queued cell switch whose inputs keep one virtual output queue per output. Each clock cycle is one cell slot. The block receives a flat occupancy bitmap with one bit per queue, where bit `i*N+j` is high when input `i` holds at least one cell for output `j`. From this it produces a registered, conflict-free map that gives, for each input, whether it is connected and to which output.

New connections come from one request-grant-accept pass per slot. Each output and each input has a round-robin pointer. A connection persists across slots. In exhaustive mode it lasts while its queue stays non-empty. In limited mode it lasts at most `LIMIT` consecutive slots. Ports that are still held are kept out of that slot's arbitration. A port that is released takes part in arbitration in the same slot in which it is released.

There is no stream data at this boundary. Both the occupancy bitmap and the match are level signals that are sampled every cycle, so there is no back-pressure. The queue logic must present, at each clock edge, the occupancy that results after the cell of the current slot has departed.

Top module: `voq_match_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every connection, so `match_vld` is 0 and `any_match` is 0. It also sets every grant and accept pointer to index 0.
- R2: A connection from input i to output j exists only if occupancy bit i*N+j was high at the edge that created or kept it.
- R3: Among the free inputs that request an output, that output grants the first one found scanning upward from its grant pointer and wrapping past N-1 to 0.
- R4: An output's grant pointer moves to one past the granted input only when that grant is accepted. A declined grant leaves the pointer unchanged.
- R5: An input that receives several grants accepts the first granting output found scanning upward from its accept pointer, with wrap. Its accept pointer then moves to one past the accepted output.
- R6: At every cycle each output is connected to at most one input. Each input holds at most one output by encoding.
- R7: When `exh_mode` is 1, a connected pair stays connected in the next slot for as long as its occupancy bit is high, with no limit on the number of slots.
- R8: When `exh_mode` is 0, a pair stays connected for at most `LIMIT` consecutive slots. After that the pair is released, and both ports rejoin arbitration in the same slot.
- R9: An input or output held by a persistent connection takes no part in that slot's request, grant or accept phases, and neither of its pointers moves.
- R10: A held pair whose occupancy bit is low at an edge is released at that edge. Its ports can be matched anew in the same slot.
- R11: Exactly one arbitration pass is made per slot. An input left without an accepted grant stays unmatched for that slot even if another output could have served it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per cell slot |
| rst | input | 1 | Synchronous active-high reset |
| exh_mode | input | 1 | 1 selects exhaustive service, 0 selects limited service |
| voq_nonempty | input | N*N | Occupancy bitmap; bit i*N+j is high when input i has cells for output j |
| match_vld | output | N | Bit i is high when input i is connected this slot |
| match_dst | output | N*clog2(N) | Field i (clog2(N) bits at i*clog2(N)) holds input i's output index |
| any_match | output | 1 | High when at least one input is connected |

## Verification
The hardest situation to reach is a slot in which some ports are released while others are still held. In such a slot, the grant pointers left behind by earlier declined and accepted grants decide the new pairs. The stimulus reaches this state by making every queue non-empty after reset in limited mode. Connections then build up one per slot, and the first release comes when other pairs are only part-way through their limit. Pointers cannot be observed directly, so they are probed through sequences that clear the bitmap and then re-request. These sequences show whether a declined grant moved a pointer.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;

  typedef enum logic {
    SVC_LIMITED    = 1'b0,
    SVC_EXHAUSTIVE = 1'b1
  } svc_mode_e;

  // index one past v, wrapping at n
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         any
);

  int c;

  // first requester at or after ptr, wrapping
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    c   = 0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        idx    = W'(c);
      end
    end
  end

endmodule

// File: rtl/voq_conn_track.sv
module voq_conn_track
  import voq_sched_pkg::*;
#(
  parameter int N     = 4,
  parameter int LIMIT = 4,
  localparam int W  = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exh_mode,
  input  logic [N-1:0] voq_row,
  input  logic         new_vld,
  input  logic [W-1:0] new_dst,
  output logic         conn_vld,
  output logic [W-1:0] conn_dst,
  output logic         hold
);

  logic [CW-1:0] cnt;
  logic          exh;

  assign exh  = (svc_mode_e'(exh_mode) == SVC_EXHAUSTIVE);
  assign hold = conn_vld && voq_row[conn_dst] && (exh || (cnt < CW'(LIMIT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_vld <= 1'b0;
      conn_dst <= '0;
      cnt      <= '0;
    end else if (hold) begin
      if (cnt < CW'(LIMIT)) cnt <= cnt + 1'b1;
    end else if (new_vld) begin
      conn_vld <= 1'b1;
      conn_dst <= new_dst;
      cnt      <= CW'(1);
    end else begin
      conn_vld <= 1'b0;
      cnt      <= '0;
    end
  end

  logic [N-1:0] dst_oh;
  assign dst_oh = N'(1) << conn_dst;

  p_match_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    conn_vld |-> |($past(voq_row) & dst_oh));

  p_hold_exh_r7: assert property (@(posedge clk) disable iff (rst)
    (exh_mode && conn_vld && voq_row[conn_dst]) |=>
      (conn_vld && conn_dst == $past(conn_dst)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT));

  p_limit_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!exh_mode && cnt == CW'(LIMIT)) |=> (cnt <= CW'(1)));

endmodule

// File: rtl/voq_match_sched.sv
module voq_match_sched
  import voq_sched_pkg::*;
#(
  parameter int N     = 4,
  parameter int LIMIT = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           exh_mode,
  input  logic [N*N-1:0] voq_nonempty,
  output logic [N-1:0]   match_vld,
  output logic [N*W-1:0] match_dst,
  output logic           any_match
);

  logic [N-1:0] hold, cvld, out_busy;
  logic [W-1:0] cdst [N];
  logic [N-1:0] rq_col [N];
  logic [N-1:0] gcol   [N];
  logic [N-1:0] grow   [N];
  logic [N-1:0] arow   [N];
  logic [W-1:0] gidx   [N];
  logic [W-1:0] aidx   [N];
  logic [W-1:0] gptr   [N];
  logic [W-1:0] aptr   [N];
  logic [N-1:0] gany, aany, out_won;
  logic [N-1:0] conn_col [N];

  // outputs reserved by held pairs
  always_comb begin
    out_busy = '0;
    for (int i = 0; i < N; i++)
      if (hold[i]) out_busy[cdst[i]] = 1'b1;
  end

  // request phase, viewed per output
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        rq_col[j][i] = voq_nonempty[i*N+j] & ~hold[i] & ~out_busy[j];
  end

  // grants transposed to per input rows
  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        grow[i][j] = gcol[j][i];
  end

  // output wins when its granted input accepts it
  always_comb begin
    for (int j = 0; j < N; j++)
      out_won[j] = gany[j] && arow[gidx[j]][j];
  end

  for (genvar g = 0; g < N; g++) begin : g_port
    voq_rr_pick #(.N(N)) u_grant (
      .req(rq_col[g]), .ptr(gptr[g]),
      .gnt(gcol[g]), .idx(gidx[g]), .any(gany[g])
    );
    voq_rr_pick #(.N(N)) u_accept (
      .req(grow[g]), .ptr(aptr[g]),
      .gnt(arow[g]), .idx(aidx[g]), .any(aany[g])
    );
    voq_conn_track #(.N(N), .LIMIT(LIMIT)) u_conn (
      .clk(clk), .rst(rst), .exh_mode(exh_mode),
      .voq_row(voq_nonempty[g*N +: N]),
      .new_vld(aany[g]), .new_dst(aidx[g]),
      .conn_vld(cvld[g]), .conn_dst(cdst[g]), .hold(hold[g])
    );
    assign match_dst[g*W +: W] = cdst[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        gptr[k] <= '0;
        aptr[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        if (out_won[k]) gptr[k] <= W'(wrap_inc(int'(gidx[k]), N));
        if (aany[k])    aptr[k] <= W'(wrap_inc(int'(aidx[k]), N));
      end
    end
  end

  assign match_vld = cvld;
  assign any_match = |cvld;

  // registered connections seen per output
  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        conn_col[j][i] = cvld[i] && (cdst[i] == W'(j));
  end

  for (genvar a = 0; a < N; a++) begin : g_chk
    p_out_excl_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(conn_col[a]));

    p_gptr_still_r4: assert property (@(posedge clk) disable iff (rst)
      !out_won[a] |=> gptr[a] == $past(gptr[a]));

    p_held_masked_r9: assert property (@(posedge clk) disable iff (rst)
      hold[a] |-> (grow[a] == '0));
  end

endmodule

// File: tb/voq_match_sched_tb.sv
`timescale 1ns/1ps
module voq_match_sched_tb_top;

  localparam int N = 4;
  localparam int LIMIT = 3;
  localparam int W = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           exh_mode;
  logic [N*N-1:0] voq;
  logic [N-1:0]   match_vld;
  logic [N*W-1:0] match_dst;
  logic           any_match;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  voq_match_sched #(.N(N), .LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst(rst), .exh_mode(exh_mode), .voq_nonempty(voq),
    .match_vld(match_vld), .match_dst(match_dst), .any_match(any_match)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int dst(input int i);
    return int'(match_dst[i*W +: W]);
  endfunction

  task automatic do_reset();
    rst = 1'b1; voq = '0; exh_mode = 1'b0;
    tick(); tick();
    check("R1 vld", int'(match_vld), 0);
    check("R1 any", int'(any_match), 0);
    rst = 1'b0;
  endtask

  // R3 grant pointer rotation, R10 drain release
  task automatic t_grant_rr();
    do_reset();
    voq = 16'h1111; tick();
    check("R3 first grant vld", int'(match_vld), 1);
    check("R3 first grant dst", dst(0), 0);
    voq = '0; tick();
    check("R10 drained", int'(match_vld), 0);
    voq = 16'h1111; tick();
    check("R3 rotated grant", int'(match_vld), 2);
  endtask

  // R4 declined grant keeps pointer, R11 one pass
  task automatic t_decline();
    do_reset();
    voq = 16'h0023; tick();
    check("R11 single pass vld", int'(match_vld), 1);
    check("R5 accept dst", dst(0), 0);
    voq = '0; tick();
    voq = 16'h0022; tick();
    check("R4 pointer kept vld", int'(match_vld), 1);
    check("R4 pointer kept dst", dst(0), 1);
  endtask

  // R5 accept pointer rotation
  task automatic t_accept_rr();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      voq = 16'h0007; tick();
      check("R5 accept rotation", dst(0), k);
      voq = '0; tick();
    end
  endtask

  // R7 exhaustive hold, R9 masking, R10 release
  task automatic t_exhaustive();
    do_reset();
    exh_mode = 1'b1;
    voq = 16'h0001; tick();
    check("R7 initial", int'(match_vld), 1);
    voq = 16'h0013;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R9 masked vld", int'(match_vld), 1);
      check("R7 held dst", dst(0), 0);
    end
    voq = 16'h0012; tick();
    check("R10 rematch vld", int'(match_vld), 3);
    check("R10 in0 dst", dst(0), 1);
    check("R10 in1 dst", dst(1), 0);
  endtask

  // R8 limited service
  task automatic t_limited();
    int exp_in [7] = '{0, 0, 0, 1, 1, 1, 0};
    do_reset();
    voq = 16'h0011;
    for (int k = 0; k < 7; k++) begin
      tick();
      check("R8 limit owner", int'(match_vld), 1 << exp_in[k]);
      check("R8 limit dst", dst(exp_in[k]), 0);
    end
  endtask

  // R6 staggered full match
  task automatic t_full();
    do_reset();
    voq = 16'hFFFF;
    tick(); check("R6 slot1", int'(match_vld), 4'b0001);
    tick(); check("R6 slot2", int'(match_vld), 4'b0011);
    tick(); check("R6 slot3", int'(match_vld), 4'b0111);
    tick(); check("R6 slot4", int'(match_vld), 4'b1111);
    check("R6 in0", dst(0), 3);
    check("R6 in1", dst(1), 1);
    check("R6 in2", dst(2), 2);
    check("R6 in3", dst(3), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; voq = '0; exh_mode = 1'b0;
    t_grant_rr();
    t_decline();
    t_accept_rr();
    t_exhaustive();
    t_limited();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule